// File: doc/BRIEF.md
# Parallel Memory Program and Verify Port

This block is the device-side end of a parallel programming interface for an on-chip nonvolatile store. An external programmer holds the device in reset and parks its control strobes high. After a short wait it pulls the fetch strobe low, and from then on the block serves byte reads and byte writes. The session lasts until the strobe is released. Each access is steered by an 8-bit command code to one of four separate spaces: code memory, configuration bytes, lock bits and the encryption array. The access address is 16 bits wide and arrives as a high byte and a low byte on two ports.

The level of a programming-voltage enable picks the direction. When the enable is low, the block drives the addressed byte onto the data port one clock later. When it is high, each falling edge of the program strobe writes the data port into the addressed byte. Reads and writes may be mixed freely inside one session. Setting any lock bit hides code memory from later reads. The storage is a plain register model with an erased value of FFh. The depth of its code region is a parameter.

Top module: `nvm_pv_port`

## Requirements
- R1: After block reset, `rdata_oe` is 0 and `rdata` is 00h. A session can only start, and can only continue, while `dev_reset` is high. Dropping `dev_reset` ends the session.
- R2: A session starts at the clock edge where `fetch_n` is sampled low, but only if the previous ENTRY_CYCLES (default 2) consecutive edges all sampled `dev_reset`=1, `fetch_n`=1, `prog_n`=1 and `mode_code`=FFh. If `fetch_n` falls earlier than that, no session starts.
- R3: A session ends at the first edge that samples `fetch_n` high. Starting a new session requires the full idle wait of R2 again.
- R4: Command 6Ch selects code memory, 6Bh the encryption array, 69h the lock bits and 68h the configuration bytes. Under any other code, a read returns FFh and a write changes nothing.
- R5: The access address is {`addr_hi`, `addr_lo`}. Addresses that differ only in the high byte select different bytes.
- R6: In a session with `vpp_en` low, `rdata_oe` is 1 one clock after the inputs are presented, and `rdata` then carries the addressed byte. In program mode (`vpp_en` high) or outside a session, `rdata_oe` is 0 and `rdata` is 00h.
- R7: In a session with `vpp_en` high, a falling edge of `prog_n` (high at one clock edge, low at the next) writes `wdata` into the addressed byte. A later verify in the same session reads that value back.
- R8: Code memory decodes 0000h to 7FFFh, but only the lowest CODE_DEPTH bytes (default 512) are stored. Their erased value is FFh. Other code addresses read FFh and ignore writes.
- R9: The two configuration bytes sit at FFF8h and FFF9h and are erased to FFh. Any other address under 68h reads FFh and ignores writes.
- R10: The encryption array covers 0000h to 007Fh and is erased to FFh. Addresses above that range read FFh and ignore writes.
- R11: Lock bits sit at addresses 0001h, 0002h and 0003h. A write sets the addressed bit, whatever the data. A read returns 01h when the bit is set and 00h when it is clear. Other addresses under 69h read FFh.
- R12: While any lock bit is set, every verify read of code memory returns FFh. The other areas read normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset; also erases the storage model |
| dev_reset | input | 1 | Device reset level; must be high for a session |
| fetch_n | input | 1 | Fetch strobe, active low; its fall opens a session |
| prog_n | input | 1 | Address-latch / program strobe; a fall writes in program mode |
| vpp_en | input | 1 | Programming-voltage enable: 1 selects program, 0 selects verify |
| mode_code | input | 8 | Command code that selects the target area |
| addr_hi | input | 8 | Address bits 15:8 |
| addr_lo | input | 8 | Address bits 7:0 |
| wdata | input | 8 | Byte to be programmed |
| rdata | output | 8 | Verified byte; 00h when not driven |
| rdata_oe | output | 1 | Output enable for rdata |

## Verification
The assertions assume that `vpp_en`, `mode_code` and the address are changed only between accesses, away from clock edges, so that each read reflects inputs that were stable at the preceding edge. They also assume that a program pulse keeps `prog_n` low for at least one full clock. The stimulus drives every input on the falling clock edge. It holds each address and code for a whole cycle, and it stretches every program pulse over a full cycle before releasing it. Entry is attempted with a short idle wait, with `dev_reset` low, and immediately after an exit. These attempts check the gating without breaking these assumptions.

// File: rtl/nvm_pv_pkg.sv
// Package: shared command codes, fixed addresses and the area type
// for the parallel program/verify port.
package nvm_pv_pkg;

    typedef enum logic [2:0] {
        AREA_NONE,
        AREA_CODE,
        AREA_CFG,
        AREA_LOCK,
        AREA_CRYPT
    } area_e;

    localparam logic [7:0]  MC_CODE  = 8'h6C;
    localparam logic [7:0]  MC_CRYPT = 8'h6B;
    localparam logic [7:0]  MC_LOCK  = 8'h69;
    localparam logic [7:0]  MC_CFG   = 8'h68;
    localparam logic [7:0]  MC_IDLE  = 8'hFF;

    localparam logic [15:0] CFG_BASE = 16'hFFF8;
    localparam logic [7:0]  ERASED   = 8'hFF;

endpackage

// File: rtl/nvm_pv_entry.sv
// Module: session sequencer.
// Counts the clock edges on which the idle condition holds (device in
// reset, both strobes high, command port at FFh). It opens a session
// when fetch_n is sampled low after ENTRY_CYCLES such edges. The
// session closes when fetch_n returns high or dev_reset drops.
// It also registers prog_n so that the falling edge can be seen.
// Assumes: inputs are synchronous to clk.
module nvm_pv_entry
    import nvm_pv_pkg::*;
#(
    parameter int ENTRY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_reset,
    input  logic       fetch_n,
    input  logic       prog_n,
    input  logic [7:0] mode_code,
    output logic       active,
    output logic       prog_fall
);

    localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(ENTRY_CYCLES);

    typedef enum logic {ST_WAIT, ST_SESSION} st_e;

    st_e              state;
    logic [CNT_W-1:0] idle_cnt;
    logic             idle_ok;
    logic             prog_q;

    assign idle_ok = dev_reset && fetch_n && prog_n && (mode_code == MC_IDLE);

    // Count consecutive idle edges, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_cnt <= '0;
        else if (state == ST_SESSION || !idle_ok)
            idle_cnt <= '0;
        else if (idle_cnt != CNT_LIM)
            idle_cnt <= idle_cnt + 1'b1;
    end

    // Open and close the session.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_WAIT;
        else begin
            case (state)
                ST_WAIT:
                    if (dev_reset && !fetch_n && idle_cnt == CNT_LIM)
                        state <= ST_SESSION;
                ST_SESSION:
                    if (!dev_reset || fetch_n)
                        state <= ST_WAIT;
                default:
                    state <= ST_WAIT;
            endcase
        end
    end

    // Delay prog_n by one cycle for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_q <= 1'b1;
        else
            prog_q <= prog_n;
    end

    assign active    = (state == ST_SESSION);
    assign prog_fall = prog_q && !prog_n;

endmodule

// File: rtl/nvm_pv_decode.sv
// Module: address decoder.
// Maps the command code and the 16-bit address to one target area
// and an index inside that area. An unknown code or an address
// outside the area gives AREA_NONE.
// Assumes: IDX_W is wide enough for the code-memory index.
module nvm_pv_decode
    import nvm_pv_pkg::*;
#(
    parameter int CODE_DEPTH  = 512,
    parameter int CRYPT_DEPTH = 128,
    parameter int CFG_COUNT   = 2,
    parameter int LOCK_COUNT  = 3,
    parameter int IDX_W       = 9
) (
    input  logic [7:0]       mode_code,
    input  logic [15:0]      addr,
    output area_e            area,
    output logic [IDX_W-1:0] idx
);

    localparam logic [16:0] CODE_LIM  = 17'(CODE_DEPTH);
    localparam logic [16:0] CRYPT_LIM = 17'(CRYPT_DEPTH);
    localparam logic [15:0] LOCK_HI   = 16'(LOCK_COUNT);
    localparam logic [16:0] CFG_END   = {1'b0, CFG_BASE} + 17'(CFG_COUNT);

    // Pick the area and the index from the code and the address.
    always_comb begin
        area = AREA_NONE;
        idx  = '0;
        case (mode_code)
            MC_CODE:
                if ({1'b0, addr} < CODE_LIM) begin
                    area = AREA_CODE;
                    idx  = IDX_W'(addr);
                end
            MC_CRYPT:
                if ({1'b0, addr} < CRYPT_LIM) begin
                    area = AREA_CRYPT;
                    idx  = IDX_W'(addr);
                end
            MC_LOCK:
                if (addr >= 16'd1 && addr <= LOCK_HI) begin
                    area = AREA_LOCK;
                    idx  = IDX_W'(addr - 16'd1);
                end
            MC_CFG:
                if (addr >= CFG_BASE && {1'b0, addr} < CFG_END) begin
                    area = AREA_CFG;
                    idx  = IDX_W'(addr - CFG_BASE);
                end
            default: ;
        endcase
    end

endmodule

// File: rtl/nvm_pv_store.sv
// Module: storage model.
// Holds code bytes, encryption bytes, configuration bytes and lock
// bits. Block reset erases everything (bytes to FFh, lock bits clear).
// The read path is combinational. When any lock bit is set, code
// reads return FFh.
// Assumes: the index is in range for the area given (the decoder
// guarantees this).
module nvm_pv_store
    import nvm_pv_pkg::*;
#(
    parameter int CODE_DEPTH  = 512,
    parameter int CRYPT_DEPTH = 128,
    parameter int CFG_COUNT   = 2,
    parameter int LOCK_COUNT  = 3,
    parameter int IDX_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  area_e            area,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_byte,
    output logic             lock_any
);

    localparam int CR_W  = (CRYPT_DEPTH > 1) ? $clog2(CRYPT_DEPTH) : 1;
    localparam int CFG_W = (CFG_COUNT   > 1) ? $clog2(CFG_COUNT)   : 1;
    localparam int LK_W  = (LOCK_COUNT  > 1) ? $clog2(LOCK_COUNT)  : 1;

    logic [7:0]            code_mem  [CODE_DEPTH];
    logic [7:0]            crypt_mem [CRYPT_DEPTH];
    logic [7:0]            cfg_mem   [CFG_COUNT];
    logic [LOCK_COUNT-1:0] lock_q;

    // Erase on reset; otherwise write the byte in the selected area.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CODE_DEPTH; i++)  code_mem[i]  <= ERASED;
            for (int i = 0; i < CRYPT_DEPTH; i++) crypt_mem[i] <= ERASED;
            for (int i = 0; i < CFG_COUNT; i++)   cfg_mem[i]   <= ERASED;
        end else if (wr_en) begin
            case (area)
                AREA_CODE:  code_mem[idx]              <= wdata;
                AREA_CRYPT: crypt_mem[idx[CR_W-1:0]]   <= wdata;
                AREA_CFG:   cfg_mem[idx[CFG_W-1:0]]    <= wdata;
                default: ;
            endcase
        end
    end

    // One set-only flop per lock bit.
    for (genvar b = 0; b < LOCK_COUNT; b++) begin : g_lock
        // Set lock bit b on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[b] <= 1'b0;
            else if (wr_en && area == AREA_LOCK && idx[LK_W-1:0] == LK_W'(b))
                lock_q[b] <= 1'b1;
        end
    end

    assign lock_any = |lock_q;

    // Select the read byte for the current area.
    always_comb begin
        case (area)
            AREA_CODE:  rd_byte = lock_any ? ERASED : code_mem[idx];
            AREA_CRYPT: rd_byte = crypt_mem[idx[CR_W-1:0]];
            AREA_CFG:   rd_byte = cfg_mem[idx[CFG_W-1:0]];
            AREA_LOCK:  rd_byte = {7'b0, lock_q[idx[LK_W-1:0]]};
            default:    rd_byte = ERASED;
        endcase
    end

endmodule

// File: rtl/nvm_pv_port.sv
// Module: top of the parallel program/verify port.
// Combines the session sequencer, the address decoder and the storage
// model. In verify mode it registers the addressed byte onto rdata
// with rdata_oe high. In program mode it writes on each falling edge
// of prog_n.
// Assumes: the programmer holds the code, address and vpp_en stable
// across each access.
module nvm_pv_port
    import nvm_pv_pkg::*;
#(
    parameter int CODE_DEPTH   = 512,
    parameter int CRYPT_DEPTH  = 128,
    parameter int CFG_COUNT    = 2,
    parameter int LOCK_COUNT   = 3,
    parameter int ENTRY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_reset,
    input  logic       fetch_n,
    input  logic       prog_n,
    input  logic       vpp_en,
    input  logic [7:0] mode_code,
    input  logic [7:0] addr_hi,
    input  logic [7:0] addr_lo,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rdata_oe
);

    localparam int IDX_W = (CODE_DEPTH > 1) ? $clog2(CODE_DEPTH) : 1;

    logic             active;
    logic             prog_fall;
    logic             lock_any;
    logic             wr_en;
    logic             verify;
    area_e            area;
    logic [IDX_W-1:0] idx;
    logic [7:0]       rd_byte;

    nvm_pv_entry #(
        .ENTRY_CYCLES (ENTRY_CYCLES)
    ) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_reset (dev_reset),
        .fetch_n   (fetch_n),
        .prog_n    (prog_n),
        .mode_code (mode_code),
        .active    (active),
        .prog_fall (prog_fall)
    );

    nvm_pv_decode #(
        .CODE_DEPTH  (CODE_DEPTH),
        .CRYPT_DEPTH (CRYPT_DEPTH),
        .CFG_COUNT   (CFG_COUNT),
        .LOCK_COUNT  (LOCK_COUNT),
        .IDX_W       (IDX_W)
    ) u_decode (
        .mode_code (mode_code),
        .addr      ({addr_hi, addr_lo}),
        .area      (area),
        .idx       (idx)
    );

    nvm_pv_store #(
        .CODE_DEPTH  (CODE_DEPTH),
        .CRYPT_DEPTH (CRYPT_DEPTH),
        .CFG_COUNT   (CFG_COUNT),
        .LOCK_COUNT  (LOCK_COUNT),
        .IDX_W       (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .area     (area),
        .idx      (idx),
        .wdata    (wdata),
        .rd_byte  (rd_byte),
        .lock_any (lock_any)
    );

    assign wr_en  = active && vpp_en && prog_fall && (area != AREA_NONE);
    assign verify = active && !vpp_en;

    // Register the verify output and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_oe <= 1'b0;
            rdata    <= 8'h00;
        end else begin
            rdata_oe <= verify;
            rdata    <= verify ? rd_byte : 8'h00;
        end
    end

endmodule

// File: rtl/nvm_pv_port_chk.sv
// Module: property checker for nvm_pv_port, attached with bind.
// Observes the top-level ports together with the internal session and
// lock state.
module nvm_pv_port_chk
    import nvm_pv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       dev_reset,
    input logic       fetch_n,
    input logic       vpp_en,
    input logic [7:0] mode_code,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic       active,
    input logic       lock_any
);

    AST_OE_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(dev_reset, 2)); // R1

    AST_ENTRY_ON_FETCH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (!$past(fetch_n) && $past(dev_reset) && $past(fetch_n, 2))); // R2

    AST_EXIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fetch_n) |=> !active); // R3

    AST_OE_NOT_IN_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !$past(vpp_en)); // R6

    AST_LOCKED_CODE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && $past(mode_code) == MC_CODE && $past(lock_any)) |-> rdata == 8'hFF); // R12

endmodule

bind nvm_pv_port nvm_pv_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_reset (dev_reset),
    .fetch_n   (fetch_n),
    .vpp_en    (vpp_en),
    .mode_code (mode_code),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe),
    .active    (active),
    .lock_any  (lock_any)
);

// File: tb/nvm_pv_port_tb.sv
// Scoreboard bench: driver tasks push expected outputs with a due
// cycle, and a monitor pops and compares them on the falling edge.
module nvm_pv_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dev_reset;
    logic       fetch_n;
    logic       prog_n;
    logic       vpp_en;
    logic [7:0] mode_code;
    logic [7:0] addr_hi;
    logic [7:0] addr_lo;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       rdata_oe;

    typedef struct {
        int         due;
        logic       oe;
        logic [7:0] data;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    int   cyc      = 0;
    int   compared = 0;
    int   failed   = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    nvm_pv_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_reset (dev_reset),
        .fetch_n   (fetch_n),
        .prog_n    (prog_n),
        .vpp_en    (vpp_en),
        .mode_code (mode_code),
        .addr_hi   (addr_hi),
        .addr_lo   (addr_lo),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    // Monitor: compare outputs against scoreboard items whose cycle is due.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                compared++;
                if (rdata_oe !== e.oe || rdata !== e.data) begin
                    failed++;
                    $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                             e.req, rdata_oe, rdata, e.oe, e.data);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_out(input logic oe, input logic [7:0] d, input string req);
        sb_q.push_back('{due: cyc + 1, oe: oe, data: d, req: req});
    endtask

    task automatic set_idle(input logic rst_lvl);
        dev_reset = rst_lvl;
        fetch_n   = 1'b1;
        prog_n    = 1'b1;
        vpp_en    = 1'b0;
        mode_code = 8'hFF;
    endtask

    task automatic enter(input logic [7:0] code);
        tick(); set_idle(1'b1);
        tick(); tick();
        fetch_n   = 1'b0;
        mode_code = code;
    endtask

    task automatic vread(input logic [7:0] code, input logic [15:0] a,
                         input logic [7:0] exp, input string req);
        tick();
        vpp_en = 1'b0; mode_code = code; {addr_hi, addr_lo} = a;
        expect_out(1'b1, exp, req);
    endtask

    task automatic vwrite(input logic [7:0] code, input logic [15:0] a, input logic [7:0] d);
        tick();
        vpp_en = 1'b1; mode_code = code; {addr_hi, addr_lo} = a; wdata = d; prog_n = 1'b1;
        tick(); prog_n = 1'b0;
        tick(); prog_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failed++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    // Driver: stimulus sequence.
    initial begin
        rst_n = 1'b0; set_idle(1'b0);
        addr_hi = 8'h00; addr_lo = 8'h00; wdata = 8'h00;
        tick(); tick();
        expect_out(1'b0, 8'h00, "R1 reset state");
        tick(); rst_n = 1'b1;

        // R1: no session without dev_reset
        tick(); set_idle(1'b0);
        tick(); tick(); tick();
        fetch_n = 1'b0; mode_code = 8'h6C;
        tick(); expect_out(1'b0, 8'h00, "R1 no device reset");
        tick(); expect_out(1'b0, 8'h00, "R1 no device reset");

        // R2: fetch falls too early
        tick(); set_idle(1'b1);
        tick(); fetch_n = 1'b0; mode_code = 8'h6C;
        tick();
        tick(); expect_out(1'b0, 8'h00, "R2 early fetch fall");

        // R2: proper entry
        enter(8'h6C);
        vread(8'h6C, 16'h0000, 8'hFF, "R2 entry then erased read");

        // R6: program mode releases the port
        tick(); vpp_en = 1'b1;
        expect_out(1'b0, 8'h00, "R6 program mode oe low");

        // R7 / R5: program and verify alternate
        vwrite(8'h6C, 16'h0010, 8'hA5);
        vwrite(8'h6C, 16'h0110, 8'hC3);
        vread(8'h6C, 16'h0010, 8'hA5, "R7 program readback");
        vread(8'h6C, 16'h0110, 8'hC3, "R5 high address byte");

        // R8: outside stored range
        vwrite(8'h6C, 16'h8010, 8'h33);
        vread(8'h6C, 16'h8010, 8'hFF, "R8 beyond code window");
        vwrite(8'h6C, 16'h0210, 8'h77);
        vread(8'h6C, 16'h0210, 8'hFF, "R8 beyond stored depth");

        // R4: unknown code
        vwrite(8'h6A, 16'h0010, 8'h00);
        vread(8'h6C, 16'h0010, 8'hA5, "R4 unknown code write ignored");
        vread(8'h6A, 16'h0010, 8'hFF, "R4 unknown code read");

        // R9: configuration bytes
        vwrite(8'h68, 16'hFFF8, 8'h12);
        vwrite(8'h68, 16'hFFF9, 8'h34);
        vwrite(8'h68, 16'hFFF7, 8'h56);
        vread(8'h68, 16'hFFF8, 8'h12, "R9 config byte 0");
        vread(8'h68, 16'hFFF9, 8'h34, "R9 config byte 1");
        vread(8'h68, 16'hFFF7, 8'hFF, "R9 below config");
        vread(8'h68, 16'hFFFA, 8'hFF, "R9 above config");

        // R10: encryption array
        vwrite(8'h6B, 16'h007F, 8'h5A);
        vwrite(8'h6B, 16'h0080, 8'h66);
        vread(8'h6B, 16'h007F, 8'h5A, "R10 crypt top byte");
        vread(8'h6B, 16'h0080, 8'hFF, "R10 beyond crypt");
        vread(8'h6B, 16'h0000, 8'hFF, "R10 crypt erased");

        // R11: lock bits
        vread(8'h69, 16'h0002, 8'h00, "R11 lock clear");
        vread(8'h6C, 16'h0010, 8'hA5, "R12 code visible before lock");
        vwrite(8'h69, 16'h0002, 8'h00);
        vread(8'h69, 16'h0002, 8'h01, "R11 lock set");
        vread(8'h69, 16'h0001, 8'h00, "R11 other lock clear");
        vread(8'h69, 16'h0004, 8'hFF, "R11 unused lock address");

        // R12: lock hides code memory only
        vread(8'h6C, 16'h0010, 8'hFF, "R12 locked code read");
        vread(8'h6B, 16'h007F, 8'h5A, "R12 crypt unaffected");
        vread(8'h68, 16'hFFF8, 8'h12, "R12 config unaffected");

        // R3: release ends the session, re-entry needs a new idle wait
        tick(); fetch_n = 1'b1; mode_code = 8'hFF;
        tick(); expect_out(1'b0, 8'h00, "R3 session closed");
        fetch_n = 1'b0; mode_code = 8'h6C;
        tick(); expect_out(1'b0, 8'h00, "R3 no re-entry without idle");

        // R1: dropping dev_reset ends a session
        enter(8'h6C);
        vread(8'h69, 16'h0002, 8'h01, "R1 session reopened");
        tick(); dev_reset = 1'b0;
        tick(); expect_out(1'b0, 8'h00, "R1 reset drop closes session");

        tick(); tick();
        done = 1'b1;
        finish_run();
    end

endmodule